// File: doc/BRIEF.md
# Wide-Ratio Audio Clock Divider

This block derives a slower clock-enable stream for an audio serial interface from a faster parent clock-enable stream. It works on pulses: the parent supplies `src_tick`, one cycle wide, and the block returns `tick_out`. That output is either the parent stream passed through unchanged, or one pulse for every N parent pulses. N is a 16-bit integer ratio.

All control sits in one 32-bit control word. The upper half holds the ratio, used as the literal divisor. The two lowest bits are a pair of enable flags. A small command port changes the word in four ways: a raw store, a ratio update, an enable and a disable. Each command follows the rules a driver would apply. The current word is always visible on `rd_data`.

Ratios 0 and 1 select bypass, in which the parent stream passes straight through. A ratio of 2 or more divides only while both enable flags are set. Otherwise the output is held low.

Top module: `audio_clk_divider`

## Requirements
- R1: After reset the control word reads 0, so the block is in bypass and `tick_out` equals `src_tick`.
- R2: A raw store (`cmd_op` = 0) makes `rd_data` equal `cmd_data` from the next cycle on.
- R3: While the ratio field (`rd_data[31:16]`) is 0 or 1, `tick_out` equals `src_tick` in the same cycle, whatever the enable flags hold.
- R4: While the ratio R is at least 2 and both enable flags (`rd_data[1:0]`) are 1, `tick_out` pulses on every R-th parent pulse counted from the last command, and on no other pulse.
- R5: While the ratio is at least 2 and the enable flags are not both 1, `tick_out` stays 0.
- R6: An enable command (`cmd_op` = 2) with ratio R of at least 2 sets the word to {R, 16'h0003}. With a ratio below 2 it leaves the word unchanged.
- R7: A disable command (`cmd_op` = 3) sets the whole word to 0.
- R8: A ratio command (`cmd_op` = 1) with argument A = `cmd_data[15:0]` sets the word to 0 when A < 2. Otherwise it sets the word to {A, 16'h0000}, which clears the enable flags.
- R9: Every accepted command restarts the divide count from zero, so after a command the first output pulse comes on the R-th parent pulse.
- R10: The full ratio 16'hFFFF divides correctly: the first pulse comes exactly on the 65535th parent pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 raw store, 1 set ratio, 2 enable, 3 disable |
| cmd_data | input | 32 | Word for a raw store; ratio in bits 15:0 for a ratio command |
| src_tick | input | 1 | Parent clock-enable pulse |
| rd_data | output | 32 | Current control word |
| tick_out | output | 1 | Divided or bypassed clock-enable pulse |

## Verification
The hardest case to reach from the ports is a restart in the middle of a period. The count must already be partway toward the ratio when a command arrives, and the command must not change the ratio. The bench enables ratio 4 and feeds two parent pulses. It then issues the same enable again and checks that the next output pulse needs four more parent pulses, not two. The full 16-bit ratio is also driven through a complete period, which confirms that the wrap point is neither off by one nor truncated.

// File: rtl/acd_pkg.sv
package acd_pkg;

    localparam int RATIO_W = 16;
    localparam int FLAG_W  = 2;
    localparam int WORD_W  = 32;
    localparam int PAD_W   = WORD_W - RATIO_W - FLAG_W;

    typedef enum logic [1:0] {
        OP_RAW     = 2'd0,
        OP_SETDIV  = 2'd1,
        OP_ENABLE  = 2'd2,
        OP_DISABLE = 2'd3
    } acd_op_e;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [PAD_W-1:0]   pad;
        logic [FLAG_W-1:0]  flags;
    } acd_word_t;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'd0,
        MODE_DIV   = 2'd1,
        MODE_GATED = 2'd2
    } acd_mode_e;

    function automatic logic ratio_is_pass(input logic [RATIO_W-1:0] r);
        return r < RATIO_W'(2);
    endfunction

    function automatic acd_mode_e word_mode(input acd_word_t w);
        if (ratio_is_pass(w.ratio))
            return MODE_PASS;
        else if (&w.flags)
            return MODE_DIV;
        else
            return MODE_GATED;
    endfunction

    function automatic acd_word_t apply_cmd(input acd_word_t cur,
                                            input acd_op_e   op,
                                            input logic [WORD_W-1:0] data);
        acd_word_t nxt;
        nxt = cur;
        unique case (op)
            OP_RAW: nxt = acd_word_t'(data);
            OP_SETDIV: begin
                if (ratio_is_pass(data[RATIO_W-1:0]))
                    nxt = '0;
                else begin
                    nxt       = '0;
                    nxt.ratio = data[RATIO_W-1:0];
                end
            end
            OP_ENABLE: begin
                if (!ratio_is_pass(cur.ratio)) begin
                    nxt       = '0;
                    nxt.ratio = cur.ratio;
                    nxt.flags = '1;
                end
            end
            OP_DISABLE: nxt = '0;
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/acd_ctl_reg.sv
module acd_ctl_reg
    import acd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  acd_op_e             cmd_op,
    input  logic [WORD_W-1:0]   cmd_data,
    output acd_word_t           word_q
);

    acd_word_t word_d;

    always_comb begin
        word_d = word_q;
        if (cmd_valid)
            word_d = apply_cmd(word_q, cmd_op, cmd_data);
    end

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else
            word_q <= word_d;
    end

    // R2
    raw_store_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == OP_RAW |=> word_q == $past(cmd_data));

    // R7
    disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == OP_DISABLE |=> word_q == '0);

    // R6
    enable_low_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == OP_ENABLE && word_q.ratio < RATIO_W'(2)
        |=> $stable(word_q));

    // R8
    setdiv_flags_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == OP_SETDIV |=> word_q.flags == '0);

endmodule

// File: rtl/acd_counter.sv
module acd_counter
    import acd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                active,
    input  logic                src_tick,
    input  logic [RATIO_W-1:0]  ratio,
    output logic                at_last
);

    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] last_idx;

    assign last_idx = ratio - RATIO_W'(1);
    assign at_last  = active && (cnt_q == last_idx);

    always_ff @(posedge clk) begin
        if (rst || restart || !active)
            cnt_q <= '0;
        else if (src_tick)
            cnt_q <= (cnt_q == last_idx) ? '0 : cnt_q + RATIO_W'(1);
    end

    // R9
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> cnt_q == '0);

    // R4
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> cnt_q < ratio);

endmodule

// File: rtl/acd_out_sel.sv
module acd_out_sel
    import acd_pkg::*;
(
    input  acd_mode_e  mode,
    input  logic       src_tick,
    input  logic       at_last,
    output logic       tick_out
);

    always_comb begin
        unique case (mode)
            MODE_PASS:  tick_out = src_tick;
            MODE_DIV:   tick_out = src_tick & at_last;
            default:    tick_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/audio_clk_divider.sv
module audio_clk_divider
    import acd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [31:0] cmd_data,
    input  logic        src_tick,
    output logic [31:0] rd_data,
    output logic        tick_out
);

    acd_word_t  word_q;
    acd_mode_e  mode;
    logic       at_last;

    acd_ctl_reg u_ctl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (acd_op_e'(cmd_op)),
        .cmd_data  (cmd_data),
        .word_q    (word_q)
    );

    assign mode = word_mode(word_q);

    acd_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .restart  (cmd_valid),
        .active   (mode == MODE_DIV),
        .src_tick (src_tick),
        .ratio    (word_q.ratio),
        .at_last  (at_last)
    );

    acd_out_sel u_sel (
        .mode     (mode),
        .src_tick (src_tick),
        .at_last  (at_last),
        .tick_out (tick_out)
    );

    assign rd_data = word_q;

    // R3
    pass_follows_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:16] < 16'd2 |-> tick_out == src_tick);

    // R5
    gated_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:16] >= 16'd2 && rd_data[1:0] != 2'b11 |-> !tick_out);

    // R4
    out_needs_src_chk: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> src_tick);

endmodule

// File: tb/tb_audio_clk_divider.sv
module tb_audio_clk_divider;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [31:0] cmd_data;
    logic        src_tick;
    logic [31:0] rd_data;
    logic        tick_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    audio_clk_divider dut (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .src_tick  (src_tick),
        .rd_data   (rd_data),
        .tick_out  (tick_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [31:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
    endtask

    task automatic run_src(input int n, output int pulses, output int first);
        pulses = 0; first = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            src_tick = 1'b1;
            #1;
            if (tick_out) begin
                pulses++;
                if (first == 0) first = i;
            end
        end
        @(negedge clk);
        src_tick = 1'b0;
    endtask

    task automatic pass_pattern(input string req);
        bit mism = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            src_tick = (i % 3) != 1;
            #1;
            if (tick_out !== src_tick) mism = 1;
        end
        @(negedge clk);
        src_tick = 1'b0;
        check(!mism, req, {31'd0, mism}, 32'd0);
    endtask

    task automatic t_reset;
        check(rd_data == 32'd0, "R1 reset word", rd_data, 32'd0);
        pass_pattern("R1 reset bypass");
    endtask

    task automatic t_raw_gated;
        int p, f;
        do_cmd(2'd0, 32'hA5A5_1234);
        check(rd_data == 32'hA5A5_1234, "R2 raw readback", rd_data, 32'hA5A5_1234);
        run_src(12, p, f);
        check(p == 0, "R5 gated flags 00", p, 0);
        do_cmd(2'd0, 32'h0007_0001);
        run_src(10, p, f);
        check(p == 0, "R5 gated flags 01", p, 0);
    endtask

    task automatic t_bypass;
        do_cmd(2'd0, 32'h0001_0003);
        check(rd_data == 32'h0001_0003, "R2 raw readback 2", rd_data, 32'h0001_0003);
        pass_pattern("R3 ratio 1 bypass");
        do_cmd(2'd0, 32'h0000_0002);
        pass_pattern("R3 ratio 0 bypass");
    endtask

    task automatic t_setdiv;
        do_cmd(2'd0, 32'h1234_5673);
        do_cmd(2'd1, 32'hFFFF_0001);
        check(rd_data == 32'd0, "R8 setdiv low", rd_data, 32'd0);
        do_cmd(2'd1, 32'hABCD_0005);
        check(rd_data == 32'h0005_0000, "R8 setdiv 5", rd_data, 32'h0005_0000);
    endtask

    task automatic t_enable_div;
        int p, f;
        do_cmd(2'd2, 32'h0);
        check(rd_data == 32'h0005_0003, "R6 enable word", rd_data, 32'h0005_0003);
        run_src(15, p, f);
        check(p == 3, "R4 ratio 5 count", p, 3);
        check(f == 5, "R4 ratio 5 first", f, 5);
        do_cmd(2'd1, 32'h0000_0002);
        do_cmd(2'd2, 32'h0);
        run_src(6, p, f);
        check(p == 3 && f == 2, "R4 ratio 2", {p[15:0], f[15:0]}, {16'd3, 16'd2});
    endtask

    task automatic t_enable_low;
        do_cmd(2'd0, 32'h0001_0002);
        do_cmd(2'd2, 32'hFFFF_FFFF);
        check(rd_data == 32'h0001_0002, "R6 enable ratio<2 unchanged", rd_data, 32'h0001_0002);
    endtask

    task automatic t_restart;
        int p, f;
        do_cmd(2'd1, 32'h0000_0004);
        do_cmd(2'd2, 32'h0);
        run_src(2, p, f);
        check(p == 0, "R9 pre-restart none", p, 0);
        do_cmd(2'd2, 32'h0);
        run_src(4, p, f);
        check(p == 1 && f == 4, "R9 restart first at 4", f, 4);
    endtask

    task automatic t_disable;
        do_cmd(2'd3, 32'hFFFF_FFFF);
        check(rd_data == 32'd0, "R7 disable word", rd_data, 32'd0);
        pass_pattern("R7 disable bypass");
    endtask

    task automatic t_max;
        int p, f;
        do_cmd(2'd1, 32'h0000_FFFF);
        do_cmd(2'd2, 32'h0);
        check(rd_data == 32'hFFFF_0003, "R10 max word", rd_data, 32'hFFFF_0003);
        run_src(65535, p, f);
        check(p == 1 && f == 65535, "R10 max first pulse", f, 65535);
    endtask

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_data = '0; src_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_raw_gated();
        t_bypass();
        t_setdiv();
        t_enable_div();
        t_enable_low();
        t_restart();
        t_disable();
        t_max();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule